// File: doc/BRIEF.md
# Pipeline Stall and Bypass Control

This block decides, cycle by cycle, how a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) handles dependences between instructions that are in flight together. It looks at the register numbers, write-enable flags and load flags held in the four pipeline registers between stages. From these it produces two ALU operand source selects and a pair of stall strobes. One strobe freezes the program counter and the fetch/decode register. The other clears the decode/execute register to a no-op.

Forwarding covers most read-after-write dependences. Each ALU operand of the instruction in execute can take its value from the execute/memory register, from the memory/writeback register, or from the register file. The younger producer wins when both match. Forwarding cannot cover a load whose result is needed by the very next instruction. For that case the block stalls the instruction in decode for one cycle. When the parameter `SHARED_MEM` is set, instructions and data share one memory port. A load in the memory stage then takes the port away from fetch, and the same one-cycle stall is applied. All decisions are combinational, so they take effect in the cycle their inputs are presented. Register 0 is hard-wired and never acts as a producer.

Top module: `pipeHazardUnit`

## Requirements
- R1: `fwdA` is 2'b10 when the execute/memory stage writes (`exmemWe`=1) a nonzero register equal to `idexRs`; `fwdA` and `fwdB` never take the value 2'b11.
- R2: `fwdA` is 2'b01 when the memory/writeback stage writes (`memwbWe`=1) a nonzero register equal to `idexRs` and the execute/memory stage does not qualify under R1.
- R3: When both later stages qualify for the same operand, the execute/memory result (2'b10) is chosen.
- R4: A stage whose destination is register 0, or whose write-enable is low, is never a forwarding source. With no qualifying source, the select is 2'b00 (register file).
- R5: `fwdB` follows the same rules as R1 to R4 using `idexRt`, independently of `fwdA`.
- R6: When the decode/execute register holds a load (`idexLoad`=1, `idexWe`=1) to a nonzero register equal to `ifidRs` or `ifidRt`, both `holdFront` and `bubbleEx` are 1 in that cycle.
- R7: With no load in execute/memory, no load-use stall is raised for a non-load producer, a load to register 0, a load with write-enable low, or a load whose destination matches neither decode source. `holdFront` and `bubbleEx` are then 0.
- R8: With `SHARED_MEM`=1, `exmemLoad`=1 raises `holdFront` and `bubbleEx` regardless of register numbers, and leaves the forwarding selects unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used by the attached checker |
| rstN | input | 1 | Active-low reset, used by the attached checker |
| ifidRs | input | REG_W | First source register of the instruction in decode |
| ifidRt | input | REG_W | Second source register of the instruction in decode |
| idexRs | input | REG_W | First ALU source register of the instruction in execute |
| idexRt | input | REG_W | Second ALU source register of the instruction in execute |
| idexRd | input | REG_W | Destination of the instruction in execute |
| idexWe | input | 1 | Register write-enable of the instruction in execute |
| idexLoad | input | 1 | Instruction in execute is a load |
| exmemRd | input | REG_W | Destination of the instruction in memory stage |
| exmemWe | input | 1 | Register write-enable of the instruction in memory stage |
| exmemLoad | input | 1 | Instruction in memory stage is a load |
| memwbRd | input | REG_W | Destination of the instruction in writeback |
| memwbWe | input | 1 | Register write-enable of the instruction in writeback |
| fwdA | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwdB | output | 2 | Operand B source, same encoding |
| holdFront | output | 1 | Freeze program counter and fetch/decode register |
| bubbleEx | output | 1 | Load a no-op into the decode/execute register |

## Verification
The checker watches every cycle for the select encoding never reaching 11, for the younger producer winning, for no forward from register 0 or from a non-writing stage, for both stall strobes always moving together, for every load-use match stalling, and for every stall having a cause. The bench scenarios are needed to show the exact select values for each distinct pattern of matching stages. They also show that the two operands are judged independently and that each exemption case (write-enable low, register 0, non-load producer, mismatched destination) leaves the outputs quiet.

// File: rtl/hzPkg.sv
package hzPkg;

  typedef enum logic [1:0] {
    FWD_RF    = 2'b00,
    FWD_MEMWB = 2'b01,
    FWD_EXMEM = 2'b10
  } fwdSel_e;

  typedef struct packed {
    logic holdFront;
    logic bubbleEx;
  } stallStrobe_t;

endpackage

// File: rtl/fwdSelect.sv
module fwdSelect #(
  parameter int REG_W   = 5,
  parameter int NUM_OPS = 2
) (
  input  logic [NUM_OPS-1:0][REG_W-1:0] srcReg,
  input  logic [REG_W-1:0]              exmemRd,
  input  logic                          exmemWe,
  input  logic [REG_W-1:0]              memwbRd,
  input  logic                          memwbWe,
  output logic [NUM_OPS-1:0][1:0]       opSel
);
  import hzPkg::*;

  logic nearLive;
  logic farLive;

  // a producer counts only if it writes a real (nonzero) register
  assign nearLive = exmemWe && (exmemRd != '0);
  assign farLive  = memwbWe && (memwbRd != '0);

  for (genvar g = 0; g < NUM_OPS; g++) begin : gOperand
    logic hitNear;
    logic hitFar;
    assign hitNear = nearLive && (exmemRd == srcReg[g]);
    assign hitFar  = farLive  && (memwbRd == srcReg[g]);
    // younger producer first
    assign opSel[g] = hitNear ? FWD_EXMEM : (hitFar ? FWD_MEMWB : FWD_RF);
  end

endmodule

// File: rtl/stallDetect.sv
module stallDetect #(
  parameter int REG_W      = 5,
  parameter bit SHARED_MEM = 1'b1
) (
  input  logic [REG_W-1:0]    ifidRs,
  input  logic [REG_W-1:0]    ifidRt,
  input  logic [REG_W-1:0]    idexRd,
  input  logic                idexWe,
  input  logic                idexLoad,
  input  logic                exmemLoad,
  output hzPkg::stallStrobe_t strobe
);
  logic loadLive;
  logic loadUse;
  logic portBusy;

  assign loadLive = idexLoad && idexWe && (idexRd != '0);
  assign loadUse  = loadLive && ((idexRd == ifidRs) || (idexRd == ifidRt));

  if (SHARED_MEM) begin : gSharedPort
    assign portBusy = exmemLoad;
  end else begin : gSplitPort
    logic unusedLoadFlag;
    assign unusedLoadFlag = exmemLoad;
    assign portBusy = 1'b0;
  end

  always_comb begin
    strobe.holdFront = loadUse || portBusy;
    strobe.bubbleEx  = loadUse || portBusy;
  end

endmodule

// File: rtl/pipeHazardUnit.sv
module pipeHazardUnit #(
  parameter int NUM_REGS   = 32,
  parameter bit SHARED_MEM = 1'b1,
  localparam int REG_W     = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] ifidRs,
  input  logic [REG_W-1:0] ifidRt,
  input  logic [REG_W-1:0] idexRs,
  input  logic [REG_W-1:0] idexRt,
  input  logic [REG_W-1:0] idexRd,
  input  logic             idexWe,
  input  logic             idexLoad,
  input  logic [REG_W-1:0] exmemRd,
  input  logic             exmemWe,
  input  logic             exmemLoad,
  input  logic [REG_W-1:0] memwbRd,
  input  logic             memwbWe,
  output logic [1:0]       fwdA,
  output logic [1:0]       fwdB,
  output logic             holdFront,
  output logic             bubbleEx
);
  import hzPkg::*;

  // clock and reset serve only the bound checker
  logic unusedClkRst;
  assign unusedClkRst = clk & rstN;

  logic [1:0][REG_W-1:0] opSrc;
  logic [1:0][1:0]       opSel;
  stallStrobe_t          strobe;

  assign opSrc[0] = idexRs;
  assign opSrc[1] = idexRt;

  fwdSelect #(.REG_W(REG_W), .NUM_OPS(2)) uFwd (
    .srcReg (opSrc),
    .exmemRd(exmemRd),
    .exmemWe(exmemWe),
    .memwbRd(memwbRd),
    .memwbWe(memwbWe),
    .opSel  (opSel)
  );

  stallDetect #(.REG_W(REG_W), .SHARED_MEM(SHARED_MEM)) uStall (
    .ifidRs   (ifidRs),
    .ifidRt   (ifidRt),
    .idexRd   (idexRd),
    .idexWe   (idexWe),
    .idexLoad (idexLoad),
    .exmemLoad(exmemLoad),
    .strobe   (strobe)
  );

  assign fwdA      = opSel[0];
  assign fwdB      = opSel[1];
  assign holdFront = strobe.holdFront;
  assign bubbleEx  = strobe.bubbleEx;

endmodule

// File: rtl/hazardChecker.sv
module hazardChecker #(
  parameter int REG_W      = 5,
  parameter bit SHARED_MEM = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] ifidRs,
  input logic [REG_W-1:0] ifidRt,
  input logic [REG_W-1:0] idexRs,
  input logic [REG_W-1:0] idexRt,
  input logic [REG_W-1:0] idexRd,
  input logic             idexWe,
  input logic             idexLoad,
  input logic [REG_W-1:0] exmemRd,
  input logic             exmemWe,
  input logic             exmemLoad,
  input logic [REG_W-1:0] memwbRd,
  input logic             memwbWe,
  input logic [1:0]       fwdA,
  input logic [1:0]       fwdB,
  input logic             holdFront,
  input logic             bubbleEx
);
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fwdA) && $onehot0(fwdB));

  p_far_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    (fwdA == 2'b01) |-> (memwbWe && memwbRd == idexRs && memwbRd != '0));

  p_near_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    (exmemWe && memwbWe && exmemRd != '0 && exmemRd == memwbRd &&
     exmemRd == idexRs) |-> (fwdA == 2'b10));

  p_zero_dest_r4: assert property (@(posedge clk) disable iff (!rstN)
    (fwdA == 2'b10 || fwdB == 2'b10) |-> (exmemWe && exmemRd != '0));

  p_operand_b_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fwdB != 2'b00) |-> (idexRt != '0));

  p_load_use_r6: assert property (@(posedge clk) disable iff (!rstN)
    (idexLoad && idexWe && idexRd != '0 && (idexRd == ifidRs || idexRd == ifidRt))
      |-> (holdFront && bubbleEx));

  p_strobe_pair_r6: assert property (@(posedge clk) disable iff (!rstN)
    holdFront == bubbleEx);

  p_stall_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    holdFront |-> (exmemLoad || (idexLoad && idexWe && idexRd != '0)));

  if (SHARED_MEM) begin : gPortCheck
    p_port_conflict_r8: assert property (@(posedge clk) disable iff (!rstN)
      exmemLoad |-> holdFront);
  end

endmodule

bind pipeHazardUnit hazardChecker #(.REG_W(REG_W), .SHARED_MEM(SHARED_MEM)) uChk (
  .clk(clk), .rstN(rstN), .ifidRs(ifidRs), .ifidRt(ifidRt),
  .idexRs(idexRs), .idexRt(idexRt), .idexRd(idexRd), .idexWe(idexWe),
  .idexLoad(idexLoad), .exmemRd(exmemRd), .exmemWe(exmemWe),
  .exmemLoad(exmemLoad), .memwbRd(memwbRd), .memwbWe(memwbWe),
  .fwdA(fwdA), .fwdB(fwdB), .holdFront(holdFront), .bubbleEx(bubbleEx)
);

// File: tb/pipeHazardUnit_test.sv
module pipeHazardUnit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] ifidRs = '0, ifidRt = '0, idexRs = '0, idexRt = '0, idexRd = '0;
  logic [4:0] exmemRd = '0, memwbRd = '0;
  logic       idexWe = 1'b0, idexLoad = 1'b0, exmemWe = 1'b0, exmemLoad = 1'b0;
  logic       memwbWe = 1'b0;
  logic [1:0] fwdA, fwdB;
  logic       holdFront, bubbleEx;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [5:0] expQ[$];
  string      tagQ[$];

  always #2 clk = ~clk;

  pipeHazardUnit uut (
    .clk(clk), .rstN(rstN), .ifidRs(ifidRs), .ifidRt(ifidRt),
    .idexRs(idexRs), .idexRt(idexRt), .idexRd(idexRd), .idexWe(idexWe),
    .idexLoad(idexLoad), .exmemRd(exmemRd), .exmemWe(exmemWe),
    .exmemLoad(exmemLoad), .memwbRd(memwbRd), .memwbWe(memwbWe),
    .fwdA(fwdA), .fwdB(fwdB), .holdFront(holdFront), .bubbleEx(bubbleEx)
  );

  // driver: apply one pipeline snapshot at a falling edge, queue its expectation
  task automatic drive(
    input logic [4:0] fRs, input logic [4:0] fRt,
    input logic [4:0] eRs, input logic [4:0] eRt, input logic [4:0] eRd,
    input logic eWe, input logic eLd,
    input logic [4:0] mRd, input logic mWe, input logic mLd,
    input logic [4:0] wRd, input logic wWe,
    input logic [1:0] xA, input logic [1:0] xB, input logic xStall,
    input string tag);
    @(negedge clk);
    ifidRs = fRs; ifidRt = fRt;
    idexRs = eRs; idexRt = eRt; idexRd = eRd; idexWe = eWe; idexLoad = eLd;
    exmemRd = mRd; exmemWe = mWe; exmemLoad = mLd;
    memwbRd = wRd; memwbWe = wWe;
    expQ.push_back({xA, xB, xStall, xStall});
    tagQ.push_back(tag);
  endtask

  // monitor: outputs are combinational, sampled half a period after driving
  always @(posedge clk) begin
    if (expQ.size() > 0) begin
      logic [5:0] exp;
      logic [5:0] got;
      string tag;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      got = {fwdA, fwdB, holdFront, bubbleEx};
      compared++;
      if (got !== exp) begin
        mismatched++;
        $display("FAIL %s: got fwdA=%b fwdB=%b hold=%b bubble=%b, expected fwdA=%b fwdB=%b hold=%b bubble=%b",
                 tag, got[5:4], got[3:2], got[1], got[0], exp[5:4], exp[3:2], exp[1], exp[0]);
      end
    end
  end

  initial begin
    //     fRs fRt eRs eRt eRd we ld  mRd mWe mLd wRd wWe  A      B     stall
    drive(0,  0,  0,  0,  0,  0, 0,  0,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R7 idle during reset");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    drive(0,  0,  5,  6,  0,  0, 0,  5,  1,  0,  0,  0,  2'b10, 2'b00, 0, "R1 exmem forward to A");
    drive(0,  0,  7,  1,  0,  0, 0,  3,  1,  0,  7,  1,  2'b01, 2'b00, 0, "R2 memwb forward to A");
    drive(0,  0,  4,  1,  0,  0, 0,  4,  1,  0,  4,  1,  2'b10, 2'b00, 0, "R3 exmem beats memwb");
    drive(0,  0,  0,  0,  0,  0, 0,  0,  1,  0,  0,  1,  2'b00, 2'b00, 0, "R4 register 0 never forwarded");
    drive(0,  0,  9,  1,  0,  0, 0,  9,  0,  0,  9,  1,  2'b01, 2'b00, 0, "R4 exmem write-enable low");
    drive(0,  0,  9,  1,  0,  0, 0,  2,  1,  0,  9,  0,  2'b00, 2'b00, 0, "R4 memwb write-enable low");
    drive(0,  0,  1, 12,  0,  0, 0, 12,  1,  0,  0,  0,  2'b00, 2'b10, 0, "R5 exmem forward to B only");
    drive(0,  0,  8,  8,  0,  0, 0,  8,  1,  0,  0,  0,  2'b10, 2'b10, 0, "R5 both operands same source");
    drive(0,  0,  2, 11,  0,  0, 0,  2,  1,  0, 11,  1,  2'b10, 2'b01, 0, "R5 operands from different stages");
    drive(6,  1,  0,  0,  6,  1, 1,  0,  0,  0,  0,  0,  2'b00, 2'b00, 1, "R6 load-use on first source");
    drive(1,  6,  0,  0,  6,  1, 1,  0,  0,  0,  0,  0,  2'b00, 2'b00, 1, "R6 load-use on second source");
    drive(6,  6,  0,  0,  6,  1, 0,  0,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R7 non-load producer");
    drive(0,  0,  0,  0,  0,  1, 1,  0,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R7 load to register 0");
    drive(6,  6,  0,  0,  6,  0, 1,  0,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R7 load with write-enable low");
    drive(7,  8,  0,  0,  6,  1, 1,  0,  0,  0,  0,  0,  2'b00, 2'b00, 0, "R7 load destination mismatched");
    drive(3,  4, 13,  1,  0,  0, 0, 13,  1,  1,  0,  0,  2'b10, 2'b00, 1, "R8 load holds the shared port");
    drive(0,  0,  0,  0,  0,  0, 0,  0,  0,  1,  0,  0,  2'b00, 2'b00, 1, "R8 port conflict with no register match");
    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL R1: %0d expectations never compared, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R1: watchdog expired, got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule